// File: doc/BRIEF.md
# Serial DAC Command Frame Transmitter

This block is the host-side sender for a low-power serial digital-to-analog converter. It takes a 12-bit output code and a 2-bit power mode through a valid/ready handshake and builds a 16-bit command word from them. It then sends the word most significant bit first over three wires: a frame select, a serial clock and a data line. The serial clock comes from the system clock through a divider that is programmable at run time. This keeps the clock below the converter's supply-dependent limit of 20 or 30 MHz.

Frame select rests low between frames to save power at the receiver. Before every frame it is driven high for a fixed number of system cycles, and its falling edge starts the frame. The serial clock rests low. Data changes on each rising edge and is held across each falling edge, where the receiver samples it. A byte mode inserts a pause after the first eight bits, as a byte-oriented serial engine would, and frame select stays low through the pause. A build option models an engine that shifts each byte least significant bit first. In that case every byte is mirrored before it is loaded, so the order on the wire stays the same. An abort input raises frame select before the sixteenth falling edge, and the receiver then discards the partial frame.

Top module: `sdac_frame_tx`

## Requirements
- R1: Each frame carries 16 bits, most significant first, with exactly 16 falling serial-clock edges. The bits are two zeros, then the mode (mode bit 1 before mode bit 0), then the 12-bit code from bit 11 down to bit 0. Mode 00 is normal operation and the other three values are power-down settings; all four pass through unchanged.
- R2: The serial clock rests low. The data line changes only at the start of a high phase, so it holds the same value across every falling edge.
- R3: Every serial-clock high phase and every ordinary low phase lasts exactly max(half_div_i, 1) system cycles.
- R4: Frame select is high for exactly FS_HI_CYC system cycles immediately before a frame's first rising clock edge. It is low during the whole frame and while idle, and the serial clock is never high while frame select is high.
- R5: When byte_mode_i is 1, the low phase after the 8th falling edge lasts max(half_div_i,1)+GAP_CYC cycles and frame select stays low. When it is 0, that low phase has the ordinary length.
- R6: cmd_ready_o is high only while idle, and busy_o is its inverse. A command is accepted when cmd_valid_i and cmd_ready_o are both high. cmd_ready_o drops in the cycle after acceptance and stays low until at least one full low phase has passed after the 16th falling edge.
- R7: abort_i sampled high during a frame before the 16th falling edge has these effects. Frame select is high and the serial clock low from the next cycle, and no more falling edges occur in that frame. After FS_HI_CYC cycles frame select returns low and cmd_ready_o rises.
- R8: abort_i while idle has no effect: frame select and the serial clock stay low and cmd_ready_o stays high.
- R9: During and right after reset, frame select, the serial clock and the data line are 0, cmd_ready_o is 1 and busy_o is 0.
- R10: With LSB_FIRST_ENGINE=1 (the default), the internal shifter sends each byte least significant bit first from a byte-mirrored load. The wire order is still the one given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Transmitter idle, command will be taken |
| cmd_code_i | input | 12 | Output code |
| cmd_mode_i | input | 2 | Power mode field |
| byte_mode_i | input | 1 | Send as two bytes with a pause between them |
| half_div_i | input | DIV_W | System cycles per serial-clock phase (0 is treated as 1) |
| abort_i | input | 1 | Cancel the frame in progress |
| busy_o | output | 1 | Frame or abort in progress |
| fs_o | output | 1 | Frame select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdo_o | output | 1 | Serial data to the converter |

## Verification
An abort and the end of a clock phase can arrive in the same system cycle. When they do, the abort must win over the phase step, the byte pause and the shift to the next bit. To provoke this, the divider is set to one, so every cycle ends a phase, and abort is raised right after the fifth falling edge. The bench then checks three things: frame select is high in the very next cycle, the edge count stays at five, and the handshake reopens after the frame-select high time. A following clean frame must then arrive intact.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 12;
  localparam int MODE_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_HI, ST_LO, ST_GAP, ST_ABT
  } sdac_st_e;

  function automatic logic [WORD_W-1:0] sdac_build(input logic [CODE_W-1:0] code,
                                                   input logic [MODE_W-1:0] mode);
    return {2'b00, mode, code};
  endfunction
endpackage

// File: rtl/sdac_word_pack.sv
module sdac_word_pack
  import sdac_pkg::*;
#(
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] raw;
  assign raw = sdac_build(code_i, mode_i);

  generate
    if (LSB_FIRST) begin : g_mirror
      for (genvar g = 0; g < WORD_W; g++) begin : g_bit
        assign word_o[g] = raw[(g / BYTE_W) * BYTE_W + (BYTE_W - 1 - (g % BYTE_W))];
      end
    end else begin : g_plain
      assign word_o = raw;
    end
  endgenerate
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  input  logic              byte_sel_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sr_q;

  generate
    if (LSB_FIRST) begin : g_lsb
      // byte engine: upper byte first, each byte shifted out from bit 0
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else if (load_i) sr_q <= word_i;
        else if (shift_i) begin
          if (!byte_sel_i) sr_q[WORD_W-1:BYTE_W] <= {1'b0, sr_q[WORD_W-1:BYTE_W+1]};
          else             sr_q[BYTE_W-1:0]      <= {1'b0, sr_q[BYTE_W-1:1]};
        end
      end
      assign bit_o = byte_sel_i ? sr_q[0] : sr_q[BYTE_W];
    end else begin : g_msb
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else if (load_i) sr_q <= word_i;
        else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
      end
      assign bit_o = sr_q[WORD_W-1];
    end
  endgenerate
endmodule

// File: rtl/sdac_phase_tmr.sv
module sdac_phase_tmr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/sdac_frame_tx.sv
module sdac_frame_tx
  import sdac_pkg::*;
#(
  parameter int DIV_W            = 8,
  parameter int FS_HI_CYC        = 2,
  parameter int GAP_CYC          = 4,
  parameter bit LSB_FIRST_ENGINE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic [MODE_W-1:0] cmd_mode_i,
  input  logic              byte_mode_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              fs_o,
  output logic              sclk_o,
  output logic              sdo_o
);
  localparam int AUX_W = $clog2(FS_HI_CYC + GAP_CYC + 2);
  localparam int CNT_W = (DIV_W > AUX_W) ? DIV_W : AUX_W;
  localparam int BIT_W = $clog2(WORD_W);

  sdac_st_e         st_q, st_d;
  logic [BIT_W-1:0] bit_q;
  logic             tmr_load, tmr_exp, sh_load, sh_shift, bit_inc, last_bit;
  logic [CNT_W-1:0] tmr_len, half_eff;
  logic [WORD_W-1:0] word;

  assign half_eff = (half_div_i == '0) ? CNT_W'(1) : CNT_W'(half_div_i);
  assign last_bit = (bit_q == BIT_W'(WORD_W - 1));

  sdac_word_pack #(.LSB_FIRST(LSB_FIRST_ENGINE)) u_pack (
    .code_i (cmd_code_i),
    .mode_i (cmd_mode_i),
    .word_o (word)
  );

  sdac_shifter #(.LSB_FIRST(LSB_FIRST_ENGINE)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .word_i     (word),
    .shift_i    (sh_shift),
    .byte_sel_i (bit_q[BIT_W-1]),
    .bit_o      (sdo_o)
  );

  sdac_phase_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (tmr_exp)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    bit_inc  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_valid_i) begin
        st_d = ST_PRE; tmr_load = 1'b1; tmr_len = CNT_W'(FS_HI_CYC); sh_load = 1'b1;
      end
      ST_PRE, ST_HI, ST_GAP: begin
        if (abort_i) begin
          st_d = ST_ABT; tmr_load = 1'b1; tmr_len = CNT_W'(FS_HI_CYC);
        end else if (tmr_exp) begin
          tmr_load = 1'b1; tmr_len = half_eff;
          if (st_q == ST_HI) st_d = ST_LO;
          else begin
            st_d = ST_HI;
            if (st_q == ST_GAP) begin sh_shift = 1'b1; bit_inc = 1'b1; end
          end
        end
      end
      ST_LO: begin
        // falling edge already happened on the last bit: abort no longer applies
        if (abort_i && !last_bit) begin
          st_d = ST_ABT; tmr_load = 1'b1; tmr_len = CNT_W'(FS_HI_CYC);
        end else if (tmr_exp) begin
          if (last_bit) st_d = ST_IDLE;
          else if (byte_mode_i && bit_q == BIT_W'(BYTE_W - 1)) begin
            st_d = ST_GAP; tmr_load = 1'b1; tmr_len = CNT_W'(GAP_CYC);
          end else begin
            st_d = ST_HI; tmr_load = 1'b1; tmr_len = half_eff;
            sh_shift = 1'b1; bit_inc = 1'b1;
          end
        end
      end
      ST_ABT: if (tmr_exp) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
    end else begin
      st_q <= st_d;
      if (sh_load) bit_q <= '0;
      else if (bit_inc) bit_q <= bit_q + 1'b1;
    end
  end

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign busy_o      = (st_q != ST_IDLE);
  assign fs_o        = (st_q == ST_PRE) || (st_q == ST_ABT);
  assign sclk_o      = (st_q == ST_HI);

  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o); // R6

  AST_SDO_STABLE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(sdo_o)); // R2

  AST_NO_SCLK_FS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !fs_o); // R4

  AST_ABORT_RAISES_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && (st_q inside {ST_PRE, ST_HI, ST_GAP} || (st_q == ST_LO && !last_bit))
    |=> fs_o && !sclk_o); // R7

  generate
    if (FS_HI_CYC >= 2) begin : g_fs_min
      AST_FS_HIGH_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(fs_o) |-> $past(fs_o, 2)); // R4
    end
  endgenerate
endmodule

// File: tb/sdac_frame_tx_tb_top.sv
module sdac_frame_tx_tb_top;
  localparam int DIV_W     = 8;
  localparam int FS_HI_CYC = 2;
  localparam int GAP_CYC   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [11:0] cmd_code = '0;
  logic [1:0]  cmd_mode = '0;
  logic        byte_mode = 1'b0;
  logic [DIV_W-1:0] half_div = 8'd2;
  logic        abort = 1'b0;
  logic        busy, fs, sclk, sdo;

  always #10 clk = ~clk;

  sdac_frame_tx #(.DIV_W(DIV_W), .FS_HI_CYC(FS_HI_CYC), .GAP_CYC(GAP_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_code_i(cmd_code), .cmd_mode_i(cmd_mode), .byte_mode_i(byte_mode),
    .half_div_i(half_div), .abort_i(abort), .busy_o(busy), .fs_o(fs),
    .sclk_o(sclk), .sdo_o(sdo)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lim);
    n_run++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s act=%0d exp>=%0d", req, act, lim);
    end
  endtask

  // wire monitor
  logic p_sclk = 0, p_fs = 0, p_sdo = 0, p_rdy = 1;
  int m_edges = 0, m_hi = 0, m_lo = 0, m_min_hi = 0, m_min_lo = 0;
  int m_fs_run = 0, m_pre = 0, m_gap = 0, m_tail = 0, m_r2_err = 0, m_r4_err = 0;
  logic [15:0] m_word = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fs) begin
        m_fs_run++;
        if (sclk) m_r4_err++;
      end else if (p_fs) begin
        m_pre = m_fs_run; m_fs_run = 0; m_edges = 0; m_word = '0;
        m_min_hi = 999; m_min_lo = 999; m_hi = 0; m_lo = 0;
      end
      if (!fs) begin
        if (sclk) begin
          if (p_sclk && sdo !== p_sdo) m_r2_err++;
          if (!p_sclk) begin
            if (m_edges == 8) m_gap = m_lo;
            else if (m_edges > 0 && m_lo < m_min_lo) m_min_lo = m_lo;
            m_lo = 0;
          end
          m_hi++;
        end else begin
          if (p_sclk) begin
            m_edges++; m_word = {m_word[14:0], p_sdo};
            if (m_hi < m_min_hi) m_min_hi = m_hi;
            m_hi = 0;
          end
          m_lo++;
        end
      end
      if (cmd_ready && !p_rdy && m_edges == 16) m_tail = m_lo;
      p_sclk = sclk; p_fs = fs; p_sdo = sdo; p_rdy = cmd_ready;
    end
  end

  typedef struct packed {
    logic [1:0]  mode;
    logic [11:0] code;
    logic        bm;
    logic [7:0]  half;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 12'hABC, 1'b0, 8'd2},
    '{2'd1, 12'h000, 1'b0, 8'd1},
    '{2'd2, 12'hFFF, 1'b1, 8'd3},
    '{2'd3, 12'h5A5, 1'b1, 8'd1},
    '{2'd0, 12'h800, 1'b0, 8'd4},
    '{2'd2, 12'h7FF, 1'b1, 8'd0}
  };

  task automatic send(input logic [1:0] mode, input logic [11:0] code);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = mode; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6 ready drop", int'(cmd_ready), 0);
    chk("R6 busy", int'(busy), 1);
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (!cmd_ready);
    @(negedge clk); #1;
  endtask

  initial begin
    #3000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    if (!done) $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R9 reset state
    #35;
    chk("R9 fs", int'(fs), 0);
    chk("R9 sclk", int'(sclk), 0);
    chk("R9 sdo", int'(sdo), 0);
    chk("R9 ready", int'(cmd_ready), 1);
    chk("R9 busy", int'(busy), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9 fs after release", int'(fs), 0);

    foreach (VECS[i]) begin
      int h;
      h = (VECS[i].half == 0) ? 1 : int'(VECS[i].half);
      byte_mode = VECS[i].bm;
      half_div  = VECS[i].half;
      send(VECS[i].mode, VECS[i].code);
      wait_ready();
      chk("R1 R10 word", int'(m_word), int'({2'b00, VECS[i].mode, VECS[i].code}));
      chk("R1 edges", m_edges, 16);
      chk("R3 high phase", m_min_hi, h);
      chk("R3 low phase", m_min_lo, h);
      chk("R4 pre high", m_pre, FS_HI_CYC);
      chk("R5 byte gap", m_gap, VECS[i].bm ? h + GAP_CYC : h);
      chk_ge("R6 tail low", m_tail, h);
      chk("R4 idle low", int'(fs), 0);
      chk("R2 idle sclk", int'(sclk), 0);
    end
    chk("R2 sdo stable high", m_r2_err, 0);
    chk("R4 sclk with fs high", m_r4_err, 0);

    // R8 abort while idle
    abort = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 fs", int'(fs), 0);
      chk("R8 ready", int'(cmd_ready), 1);
      chk("R8 sclk", int'(sclk), 0);
    end
    abort = 1'b0;

    // R7 abort coinciding with phase expiry (half = 1)
    byte_mode = 1'b0; half_div = 8'd1;
    send(2'd1, 12'h3C3);
    do begin @(negedge clk); #1; end while (m_edges != 5);
    abort = 1'b1;
    @(negedge clk); #1;
    abort = 1'b0;
    chk("R7 fs high", int'(fs), 1);
    chk("R7 sclk low", int'(sclk), 0);
    chk("R7 edges frozen", m_edges, 5);
    chk("R7 still busy", int'(cmd_ready), 0);
    for (int k = 0; k < FS_HI_CYC; k++) @(negedge clk);
    #1;
    chk("R7 fs back low", int'(fs), 0);
    chk("R7 ready", int'(cmd_ready), 1);

    // clean frame after abort
    half_div = 8'd2;
    send(2'd3, 12'h123);
    wait_ready();
    chk("R1 word after abort", int'(m_word), int'({2'b00, 2'd3, 12'h123}));
    chk("R1 edges after abort", m_edges, 16);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule